// File: doc/BRIEF.md
# Programmable Almost-Empty / Almost-Full Threshold Unit

This block sits beside a dual-clock FIFO core and turns the core's fill information into two early-warning flags. It keeps one threshold for the almost-empty side and one for the almost-full side. The almost-empty flag compares the stored word count against its threshold, counting up from the empty boundary. The almost-full flag compares the free space against its threshold, counting down from the full boundary. The almost-full flag is registered on the write clock and the almost-empty flag on the read clock.

While master reset is held, a two-bit select input places a default value of 8, 16 or 64 words into both thresholds. The same reset also samples a mode pin that fixes how thresholds are loaded afterwards. In parallel mode a load strobe takes a whole threshold from the write data bus. In serial mode each strobed write-clock edge takes one bit from a serial input. A partial reset restarts the loading sequence but keeps both thresholds and the chosen mode. The load strobe has no ready signal: every strobed edge is accepted and no back-pressure exists. The read-side copy of the almost-empty threshold crosses clock domains through a two-stage synchronizer. Thresholds are therefore expected to change only while the read side can tolerate a few cycles of settling.

Top module: `almost_flag_unit`

## Requirements
- R1: While `mrst_n` is low, each `wr_clk` edge sets both thresholds from `dflt_sel`: 00 gives 8, 01 gives 16, 10 and 11 give 64. Master reset also restarts the loading sequence at the almost-empty threshold, bit 0.
- R2: The loading mode is captured from `ser_mode_pin` while `mrst_n` is low (1 = serial, 0 = parallel). It is held until the next master reset, whatever the pin does.
- R3: In parallel mode, strobed edges alternate. The first takes `wdata[OW-1:0]` as the almost-empty threshold, the second takes it as the almost-full threshold, and the sequence then repeats.
- R4: In serial mode, each strobed edge takes one bit from `ser_din`, LSB first. The first OW bits form the almost-empty threshold, the next OW bits form the almost-full threshold, and the sequence then returns to the almost-empty threshold.
- R5: While `prst_n` is low (and `mrst_n` is high), the thresholds and the mode are unchanged and loading is ignored. The loading sequence restarts at the almost-empty threshold.
- R6: Without `load_en`, activity on `wdata` and `ser_din` changes neither threshold.
- R7: `almost_full` is registered on `wr_clk` and is 1 exactly when `wr_free` is at or below the almost-full threshold. It is 0 during master reset.
- R8: `almost_empty` is registered on `rd_clk` and is 1 exactly when `rd_count` is at or below the almost-empty threshold. A new threshold takes effect within three `rd_clk` cycles after it is loaded. The flag is 1 during master reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low, synchronous on each clock |
| prst_n | input | 1 | Partial reset, active low, write clock |
| dflt_sel | input | 2 | Default threshold select, sampled in master reset |
| ser_mode_pin | input | 1 | Loading method select, sampled in master reset |
| load_en | input | 1 | Threshold load strobe |
| wdata | input | DW | Write data bus, parallel threshold source |
| ser_din | input | 1 | Serial threshold bit |
| wr_free | input | OW | Free words, write-clock domain |
| rd_count | input | OW | Stored words, read-clock domain |
| almost_full | output | 1 | Free space at or below the almost-full threshold |
| almost_empty | output | 1 | Word count at or below the almost-empty threshold |

## Verification
The assertions check on every cycle that master reset loads the selected default, and that the captured mode changes only under master reset. They also check that partial reset and unstrobed edges leave the thresholds alone, that a parallel load touches only one threshold, and that an empty level always raises its flag. Only the bench's scenarios can show that values land in the correct threshold and bit order. They also cover the exact flag boundary at each default, and that partial reset restarts the sequence at the almost-empty threshold.

// File: rtl/afl_pkg.sv
package afl_pkg;
  localparam int DFLT_W = 7;

  // Default threshold chosen by the two-bit select during master reset.
  function automatic logic [DFLT_W-1:0] dflt_thresh(input logic [1:0] sel);
    case (sel)
      2'b00:   return 7'd8;
      2'b01:   return 7'd16;
      default: return 7'd64;
    endcase
  endfunction
endpackage

// File: rtl/afl_thresh_loader.sv
module afl_thresh_loader #(
  parameter int OW = 9,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic [1:0]    dflt_sel,
  input  logic          ser_mode_pin,
  input  logic          load_en,
  input  logic [DW-1:0] wdata,
  input  logic          ser_din,
  output logic [OW-1:0] ae_thr,
  output logic [OW-1:0] af_thr,
  output logic          ser_mode
);
  import afl_pkg::*;

  localparam int NBITS = 2 * OW;
  localparam int SW    = $clog2(NBITS);

  logic [SW-1:0] bit_idx;
  logic          par_to_af;

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      ae_thr    <= OW'(dflt_thresh(dflt_sel));
      af_thr    <= OW'(dflt_thresh(dflt_sel));
      ser_mode  <= ser_mode_pin;
      bit_idx   <= '0;
      par_to_af <= 1'b0;
    end else if (!prst_n) begin
      bit_idx   <= '0;
      par_to_af <= 1'b0;
    end else if (load_en) begin
      if (ser_mode) begin
        if (bit_idx < SW'(OW)) ae_thr <= {ser_din, ae_thr[OW-1:1]};
        else                   af_thr <= {ser_din, af_thr[OW-1:1]};
        bit_idx <= (bit_idx == SW'(NBITS - 1)) ? '0 : bit_idx + 1'b1;
      end else begin
        if (par_to_af) af_thr <= wdata[OW-1:0];
        else           ae_thr <= wdata[OW-1:0];
        par_to_af <= ~par_to_af;
      end
    end
  end

  AST_DFLT_ON_MRST: assert property (@(posedge clk) disable iff (1'b0)
    !mrst_n |=> (ae_thr == OW'(dflt_thresh($past(dflt_sel))) &&
                 af_thr == OW'(dflt_thresh($past(dflt_sel))))); // R1
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!mrst_n)
    1'b1 |=> $stable(ser_mode)); // R2
  AST_PAR_ONE_THR: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
    (load_en && !ser_mode) |=> ($stable(ae_thr) || $stable(af_thr))); // R3
  AST_PRST_KEEPS: assert property (@(posedge clk) disable iff (!mrst_n)
    !prst_n |=> ($stable(ae_thr) && $stable(af_thr))); // R5
  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!mrst_n)
    !load_en |=> ($stable(ae_thr) && $stable(af_thr))); // R6
endmodule

// File: rtl/afl_bus_sync.sv
module afl_bus_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[i] <= '0;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/afl_level_flag.sv
module afl_level_flag #(
  parameter int   W       = 9,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] thr,
  output logic         flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) flag <= RST_VAL;
    else        flag <= (level <= thr);
  end

  AST_ZERO_LEVEL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |=> flag); // R7 R8
endmodule

// File: rtl/almost_flag_unit.sv
module almost_flag_unit #(
  parameter int DEPTH = 256,
  parameter int DW    = 16,
  parameter int OW    = $clog2(DEPTH) + 1
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic [1:0]    dflt_sel,
  input  logic          ser_mode_pin,
  input  logic          load_en,
  input  logic [DW-1:0] wdata,
  input  logic          ser_din,
  input  logic [OW-1:0] wr_free,
  input  logic [OW-1:0] rd_count,
  output logic          almost_full,
  output logic          almost_empty
);
  logic [OW-1:0] ae_thr_w, af_thr_w, ae_thr_r;
  logic          ser_mode;

  afl_thresh_loader #(.OW(OW), .DW(DW)) u_loader (
    .clk(wr_clk), .mrst_n(mrst_n), .prst_n(prst_n), .dflt_sel(dflt_sel),
    .ser_mode_pin(ser_mode_pin), .load_en(load_en), .wdata(wdata),
    .ser_din(ser_din), .ae_thr(ae_thr_w), .af_thr(af_thr_w), .ser_mode(ser_mode)
  );

  afl_bus_sync #(.W(OW), .STAGES(2)) u_ae_sync (
    .clk(rd_clk), .rst_n(mrst_n), .d(ae_thr_w), .q(ae_thr_r)
  );

  afl_level_flag #(.W(OW), .RST_VAL(1'b0)) u_af_flag (
    .clk(wr_clk), .rst_n(mrst_n), .level(wr_free), .thr(af_thr_w), .flag(almost_full)
  );

  afl_level_flag #(.W(OW), .RST_VAL(1'b1)) u_ae_flag (
    .clk(rd_clk), .rst_n(mrst_n), .level(rd_count), .thr(ae_thr_r), .flag(almost_empty)
  );
endmodule

// File: tb/almost_flag_unit_test.sv
module almost_flag_unit_test;
  localparam int OW = 9;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic mrst_n = 1'b0, prst_n = 1'b1, ser_mode_pin = 1'b0, load_en = 1'b0, ser_din = 1'b0;
  logic [1:0] dflt_sel = 2'b00;
  logic [DW-1:0] wdata = '0;
  logic [OW-1:0] wr_free = '0, rd_count = '0;
  logic almost_full, almost_empty;

  int checks = 0, failures = 0;
  bit done = 0;

  almost_flag_unit #(.DEPTH(256), .DW(DW)) uut (
    .wr_clk(clk), .rd_clk(clk), .mrst_n(mrst_n), .prst_n(prst_n),
    .dflt_sel(dflt_sel), .ser_mode_pin(ser_mode_pin), .load_en(load_en),
    .wdata(wdata), .ser_din(ser_din), .wr_free(wr_free), .rd_count(rd_count),
    .almost_full(almost_full), .almost_empty(almost_empty)
  );

  // {sel[1:0], free[8:0], count[8:0], exp_af, exp_ae}
  localparam logic [21:0] VEC [8] = '{
    {2'b00, 9'd8,   9'd9,  1'b1, 1'b0},
    {2'b00, 9'd9,   9'd8,  1'b0, 1'b1},
    {2'b01, 9'd16,  9'd17, 1'b1, 1'b0},
    {2'b01, 9'd17,  9'd16, 1'b0, 1'b1},
    {2'b10, 9'd64,  9'd65, 1'b1, 1'b0},
    {2'b10, 9'd65,  9'd64, 1'b0, 1'b1},
    {2'b11, 9'd64,  9'd0,  1'b1, 1'b1},
    {2'b11, 9'd200, 9'd65, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_mrst(input logic [1:0] sel, input logic smode);
    mrst_n = 1'b0; dflt_sel = sel; ser_mode_pin = smode;
    wait_n(3);
    mrst_n = 1'b1;
    wait_n(1);
  endtask

  task automatic probe(input string req, input int fr, input int cn, input logic eaf, input logic eae);
    wr_free = OW'(fr); rd_count = OW'(cn);
    wait_n(4);
    check({req, " almost_full"}, almost_full, eaf);
    check({req, " almost_empty"}, almost_empty, eae);
  endtask

  task automatic par_load(input int v);
    wdata = DW'(v); load_en = 1'b1;
    wait_n(1);
    load_en = 1'b0; wdata = '0;
  endtask

  task automatic ser_load(input int ae, input int af);
    for (int i = 0; i < 2*OW; i++) begin
      ser_din = (i < OW) ? ae[i] : af[i-OW];
      load_en = 1'b1;
      wait_n(1);
    end
    load_en = 1'b0; ser_din = 1'b0;
  endtask

  initial begin
    wait_n(1);
    // R7 R8: reset values with levels that would otherwise flip both flags
    wr_free = '0; rd_count = 9'd256;
    wait_n(2);
    check("R7 reset value", almost_full, 1'b0);
    check("R8 reset value", almost_empty, 1'b1);

    // R1 R7 R8: default thresholds at their boundaries
    foreach (VEC[k]) begin
      do_mrst(VEC[k][21:20], 1'b0);
      probe("R1 default", int'(VEC[k][19:11]), int'(VEC[k][10:2]), VEC[k][1], VEC[k][0]);
    end

    // R3: parallel loading, AE first then AF; R2 pin changes after reset are ignored
    do_mrst(2'b00, 1'b0);
    ser_mode_pin = 1'b1;
    par_load(20);
    par_load(30);
    probe("R3 R2 parallel at", 30, 20, 1'b1, 1'b1);
    probe("R3 parallel above", 31, 21, 1'b0, 1'b0);

    // R5: partial reset keeps thresholds and restarts the sequence at AE
    par_load(40);
    prst_n = 1'b0; wait_n(2);
    wdata = DW'(5); load_en = 1'b1; wait_n(1); load_en = 1'b0;
    prst_n = 1'b1;
    probe("R5 kept", 30, 40, 1'b1, 1'b1);
    probe("R5 kept above", 31, 41, 1'b0, 1'b0);
    par_load(50);
    probe("R5 restart AE", 31, 50, 1'b0, 1'b1);
    probe("R5 AF untouched", 30, 51, 1'b1, 1'b0);

    // R6: unstrobed bus activity is ignored
    for (int i = 0; i < 6; i++) begin
      wdata = DW'(200 + i); ser_din = i[0];
      wait_n(1);
    end
    probe("R6 ignored", 31, 50, 1'b0, 1'b1);
    probe("R6 ignored above", 30, 51, 1'b1, 1'b0);

    // R4: serial loading, AE bits then AF bits, LSB first
    do_mrst(2'b01, 1'b1);
    ser_load(100, 5);
    probe("R4 serial at", 5, 100, 1'b1, 1'b1);
    probe("R4 serial above", 6, 101, 1'b0, 1'b0);
    // R4: sequence wraps back to AE; R2 serial mode held though pin is low
    ser_mode_pin = 1'b0;
    ser_load(256, 3);
    probe("R4 R2 wrap at", 3, 256, 1'b1, 1'b1);
    probe("R4 wrap above", 4, 0, 1'b0, 1'b1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule